// File: doc/BRIEF.md
# Sync Format Change Event Recorder

This block keeps a small set of sticky event flags for a video input sync path. Its main job is to notice that the incoming video format has changed, even when the sync type is unchanged. It does this by comparing each fresh measurement against a stored baseline: the HSYNC and VSYNC polarities, the vertical line total, the VSYNC pulse width and the HSYNC period. Each numeric quantity has its own programmable tolerance, so small jitter in a measurement is not reported as a new format.

Other flags record a change in the 2-bit detected sync type on each input port. One more flag records the first point after a clear at which both HSYNC and VSYNC have been seen. The measurement engines sit outside the block. They present values together with single-cycle update strobes.

Software clears each flag by writing 1 to its bit. A flag records nothing until it has been cleared at least once after reset. Clearing the format-change flag also discards the stored baselines, so the next sample of each quantity becomes the new reference.

Top module: `sync_evt_rec`

## Requirements
- R1: After reset all flags read 0, and no event sets any flag until that flag has been cleared once by a write of 1.
- R2: A cycle with `clr_wr`=1 clears every flag whose `clr_mask` bit is 1 and arms it for recording. Flags whose mask bit is 0 keep their value. Flag bit order: bit 0 format change, bits 1..NPORT port sync-type change, bit NPORT+1 sync valid.
- R3: After the format flag is cleared, the first strobed sample of each measurement becomes its baseline and does not set the flag.
- R4: A vertical total sample sets the format flag when its absolute difference from the baseline exceeds `vtot_tol` lines. A difference equal to the tolerance does not set it.
- R5: A VSYNC width sample sets the format flag when its absolute difference from the baseline exceeds `vwid_tol` lines.
- R6: An HSYNC period sample sets the format flag when its absolute difference exceeds `hper_tol` times 64 counts. With a field of 1, a difference of 64 is ignored and a difference of 65 is flagged.
- R7: A polarity sample sets the format flag when either the HSYNC or the VSYNC polarity bit differs from the baseline pair.
- R8: A sample that is flagged as a change replaces that measurement's baseline. A sample that lies within tolerance leaves the baseline unchanged.
- R9: Flag bit 1+p is set in the clock edge that samples a new value of port p's 2-bit sync type.
- R10: The sync-valid flag is set once both `hs_det` and `vs_det` have pulsed since the flag was cleared. It appears one edge after the later of the two pulses is latched.
- R11: A set flag stays set until it is cleared. If an armed event and a clear of the same bit fall in the same cycle, the flag ends up set.
- R12: When the format flag is cleared, a sample strobed in the same cycle becomes the new baseline. It is not compared against a later value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_pol | input | 1 | Measured HSYNC polarity |
| vs_pol | input | 1 | Measured VSYNC polarity |
| pol_vld | input | 1 | Strobe for the polarity pair |
| vtot | input | VT_W | Measured vertical total, in lines |
| vtot_vld | input | 1 | Strobe for vtot |
| vwid | input | VW_W | Measured VSYNC width, in lines |
| vwid_vld | input | 1 | Strobe for vwid |
| hper | input | HP_W | Measured HSYNC period, in counts |
| hper_vld | input | 1 | Strobe for hper |
| vtot_tol | input | VT_TOL_W | Vertical total tolerance, in lines |
| vwid_tol | input | VW_TOL_W | VSYNC width tolerance, in lines |
| hper_tol | input | HP_TOL_W | HSYNC period tolerance, in units of 2^HP_TOL_SHIFT counts |
| port_type | input | NPORT*TW | Detected sync type per port, port p in bits [p*TW +: TW] |
| hs_det | input | 1 | Pulse: HSYNC detected |
| vs_det | input | 1 | Pulse: VSYNC detected |
| clr_wr | input | 1 | Write-1 clear strobe |
| clr_mask | input | NPORT+2 | Flags to clear when clr_wr is 1 |
| flags | output | NPORT+2 | Sticky event flags |

## Verification
Measurement strobes, clears and port-type changes all act on the single clock edge that samples them. Their effect on `flags` is therefore visible directly after that edge. The bench drives each stimulus on a falling edge and reads the flags on the next falling edge. The sync-valid flag passes through one more register, the seen latches, so it is due one edge later. The bench checks that it is still 0 at the first falling edge and 1 at the second. The checks on baseline handling use values that a wrong baseline would classify the other way, so that R8 and R12 are observable through the flag alone.

// File: rtl/sync_evt_pkg.sv
package sync_evt_pkg;
   // Bit positions inside the flag vector
   localparam int FLG_FMT       = 0;
   localparam int FLG_PORT_BASE = 1;

   typedef struct packed {
      logic hs;
      logic vs;
   } pol_pair_t;
endpackage

// File: rtl/evt_tol_cmp.sv
// Baseline register with tolerance compare for one measured quantity.
module evt_tol_cmp #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rebase,
   input  logic         smp_vld,
   input  logic [W-1:0] smp,
   input  logic [W-1:0] tol,
   output logic         chg
);
   logic [W-1:0] base_q;
   logic         base_vld_q;
   logic [W-1:0] delta;

   always_comb begin
      delta = (smp >= base_q) ? (smp - base_q) : (base_q - smp);
      chg   = smp_vld && base_vld_q && (delta > tol);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q     <= '0;
         base_vld_q <= 1'b0;
      end else if (rebase) begin
         base_vld_q <= smp_vld;
         if (smp_vld) base_q <= smp;
      end else if (smp_vld && (!base_vld_q || chg)) begin
         base_q     <= smp;
         base_vld_q <= 1'b1;
      end
   end
endmodule

// File: rtl/evt_type_watch.sv
// Reports any change of a detected sync type code between consecutive cycles.
module evt_type_watch #(
   parameter int TW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] typ,
   output logic          chg
);
   logic [TW-1:0] prev_q;
   logic          prev_vld_q;

   assign chg = prev_vld_q && (typ != prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= '0;
         prev_vld_q <= 1'b0;
      end else begin
         prev_q     <= typ;
         prev_vld_q <= 1'b1;
      end
   end
endmodule

// File: rtl/evt_flag_bank.sv
// Sticky write-1-to-clear flags, each armed by its first clear.
module evt_flag_bank #(
   parameter int NF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] evt,
   input  logic          clr_wr,
   input  logic [NF-1:0] clr_mask,
   output logic [NF-1:0] flags
);
   logic [NF-1:0] armed_q;
   logic [NF-1:0] flag_q;
   logic [NF-1:0] clr_v;

   assign clr_v = clr_mask & {NF{clr_wr}};
   assign flags = flag_q;

   for (genvar i = 0; i < NF; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[i]  <= 1'b0;
            armed_q[i] <= 1'b0;
         end else begin
            // a recorded event outranks a clear in the same cycle
            flag_q[i]  <= (flag_q[i] & ~clr_v[i]) | (evt[i] & armed_q[i]);
            armed_q[i] <= armed_q[i] | clr_v[i];
         end
      end
   end
endmodule

// File: rtl/sync_evt_rec.sv
module sync_evt_rec
   import sync_evt_pkg::*;
#(
   parameter int VT_W         = 12,
   parameter int VW_W         = 6,
   parameter int HP_W         = 20,
   parameter int VT_TOL_W     = 3,
   parameter int VW_TOL_W     = 2,
   parameter int HP_TOL_W     = 3,
   parameter int HP_TOL_SHIFT = 6,
   parameter int NPORT        = 2,
   parameter int TW           = 2,
   localparam int NF          = NPORT + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hs_pol,
   input  logic                vs_pol,
   input  logic                pol_vld,
   input  logic [VT_W-1:0]     vtot,
   input  logic                vtot_vld,
   input  logic [VW_W-1:0]     vwid,
   input  logic                vwid_vld,
   input  logic [HP_W-1:0]     hper,
   input  logic                hper_vld,
   input  logic [VT_TOL_W-1:0] vtot_tol,
   input  logic [VW_TOL_W-1:0] vwid_tol,
   input  logic [HP_TOL_W-1:0] hper_tol,
   input  logic [NPORT*TW-1:0] port_type,
   input  logic                hs_det,
   input  logic                vs_det,
   input  logic                clr_wr,
   input  logic [NF-1:0]       clr_mask,
   output logic [NF-1:0]       flags
);
   localparam int FLG_SYNC = NF - 1;

   // elaboration-time parameter checks
   if (VT_W < VT_TOL_W) begin : g_bad_vt
      $error("VT_W must hold the vertical total tolerance");
   end
   if (VW_W < VW_TOL_W) begin : g_bad_vw
      $error("VW_W must hold the VSYNC width tolerance");
   end
   if (HP_W < HP_TOL_W + HP_TOL_SHIFT) begin : g_bad_hp
      $error("HP_W must hold the scaled HSYNC period tolerance");
   end
   if (NPORT < 1 || TW < 1) begin : g_bad_port
      $error("NPORT and TW must be at least 1");
   end

   logic [NF-1:0] evt;
   logic          rebase;
   logic          pol_chg, vt_chg, vw_chg, hp_chg;
   pol_pair_t     pol_now;
   logic [VT_W-1:0] vt_tol_x;
   logic [VW_W-1:0] vw_tol_x;
   logic [HP_W-1:0] hp_tol_x;

   assign rebase   = clr_wr & clr_mask[FLG_FMT];
   assign pol_now  = '{hs: hs_pol, vs: vs_pol};
   assign vt_tol_x = VT_W'(vtot_tol);
   assign vw_tol_x = VW_W'(vwid_tol);
   assign hp_tol_x = HP_W'(hper_tol) << HP_TOL_SHIFT;

   evt_tol_cmp #(.W(2)) u_cmp_pol (
      .clk(clk), .rst_n(rst_n), .rebase(rebase), .smp_vld(pol_vld),
      .smp(pol_now), .tol(2'b00), .chg(pol_chg));

   evt_tol_cmp #(.W(VT_W)) u_cmp_vt (
      .clk(clk), .rst_n(rst_n), .rebase(rebase), .smp_vld(vtot_vld),
      .smp(vtot), .tol(vt_tol_x), .chg(vt_chg));

   evt_tol_cmp #(.W(VW_W)) u_cmp_vw (
      .clk(clk), .rst_n(rst_n), .rebase(rebase), .smp_vld(vwid_vld),
      .smp(vwid), .tol(vw_tol_x), .chg(vw_chg));

   evt_tol_cmp #(.W(HP_W)) u_cmp_hp (
      .clk(clk), .rst_n(rst_n), .rebase(rebase), .smp_vld(hper_vld),
      .smp(hper), .tol(hp_tol_x), .chg(hp_chg));

   assign evt[FLG_FMT] = pol_chg | vt_chg | vw_chg | hp_chg;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      evt_type_watch #(.TW(TW)) u_watch (
         .clk(clk), .rst_n(rst_n),
         .typ(port_type[p*TW +: TW]),
         .chg(evt[FLG_PORT_BASE + p]));
   end

   // sync-valid: latch each detection, fire once when both are held
   logic hs_got_q, vs_got_q, sv_done_q, sv_evt, sv_clr;
   assign sv_clr = clr_wr & clr_mask[FLG_SYNC];
   assign sv_evt = hs_got_q & vs_got_q & ~sv_done_q;
   assign evt[FLG_SYNC] = sv_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_got_q  <= 1'b0;
         vs_got_q  <= 1'b0;
         sv_done_q <= 1'b0;
      end else if (sv_clr) begin
         hs_got_q  <= 1'b0;
         vs_got_q  <= 1'b0;
         sv_done_q <= 1'b0;
      end else begin
         hs_got_q  <= hs_got_q | hs_det;
         vs_got_q  <= vs_got_q | vs_det;
         sv_done_q <= sv_done_q | sv_evt;
      end
   end

   evt_flag_bank #(.NF(NF)) u_bank (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .clr_wr(clr_wr), .clr_mask(clr_mask), .flags(flags));
endmodule

// File: rtl/sync_evt_rec_chk.sv
module sync_evt_rec_chk #(
   parameter int NPORT = 2,
   parameter int TW    = 2,
   localparam int NF   = NPORT + 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NF-1:0]       flags,
   input logic                clr_wr,
   input logic [NF-1:0]       clr_mask,
   input logic                any_vld,
   input logic [NPORT*TW-1:0] port_type
);
   // R1: flags held at zero while reset is applied
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_zero_R1: assert (flags == '0);
      end
   end

   // R11: a set flag only drops through a clear of its own bit
   for (genvar i = 0; i < NF; i++) begin : g_sticky
      assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
         flags[i] && !(clr_wr && clr_mask[i]) |=> flags[i]);
   end

   // R4/R5/R6/R7: format flag only rises after a measurement strobe
   assert_fmt_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(any_vld));

   // R9: a port flag only rises after that port's type changed
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assert_port_needs_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flags[1+p]) |->
            ($past(port_type[p*TW +: TW]) != $past(port_type[p*TW +: TW], 2)));
   end
endmodule

bind sync_evt_rec sync_evt_rec_chk #(.NPORT(NPORT), .TW(TW)) u_chk (
   .clk(clk), .rst_n(rst_n), .flags(flags), .clr_wr(clr_wr),
   .clr_mask(clr_mask),
   .any_vld(pol_vld | vtot_vld | vwid_vld | hper_vld),
   .port_type(port_type));

// File: tb/sync_evt_rec_bench.sv
module sync_evt_rec_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hs_pol = 0, vs_pol = 0, pol_vld = 0;
   logic [11:0] vtot = '0;
   logic        vtot_vld = 0;
   logic [5:0]  vwid = '0;
   logic        vwid_vld = 0;
   logic [19:0] hper = '0;
   logic        hper_vld = 0;
   logic [2:0]  vtot_tol = 3'd1;
   logic [1:0]  vwid_tol = 2'd2;
   logic [2:0]  hper_tol = 3'd1;
   logic [3:0]  port_type = '0;
   logic        hs_det = 0, vs_det = 0;
   logic        clr_wr = 0;
   logic [3:0]  clr_mask = '0;
   logic [3:0]  flags;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sync_evt_rec u_sync_evt_rec (
      .clk(clk), .rst_n(rst_n), .hs_pol(hs_pol), .vs_pol(vs_pol),
      .pol_vld(pol_vld), .vtot(vtot), .vtot_vld(vtot_vld), .vwid(vwid),
      .vwid_vld(vwid_vld), .hper(hper), .hper_vld(hper_vld),
      .vtot_tol(vtot_tol), .vwid_tol(vwid_tol), .hper_tol(hper_tol),
      .port_type(port_type), .hs_det(hs_det), .vs_det(vs_det),
      .clr_wr(clr_wr), .clr_mask(clr_mask), .flags(flags));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   // finish the current cycle: drop all strobes after the sampling edge
   task automatic step();
      @(negedge clk);
      pol_vld = 0; vtot_vld = 0; vwid_vld = 0; hper_vld = 0;
      clr_wr = 0; hs_det = 0; vs_det = 0;
   endtask

   task automatic clr(input logic [3:0] m);
      clr_wr = 1; clr_mask = m; step();
   endtask

   task automatic vt(input int v);
      vtot = 12'(v); vtot_vld = 1; step();
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset", 32'(flags), 0);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic t_unarmed();
      port_type = 4'b0010; step();
      vt(100); vt(300);
      hs_det = 1; vs_det = 1; step(); step(); step();
      chk("R1 unarmed", 32'(flags), 0);
      clr(4'hF);
      chk("R2 clear all", 32'(flags), 0);
   endtask

   task automatic t_baseline();
      vt(525);
      vwid = 6; vwid_vld = 1; step();
      hper = 50000; hper_vld = 1; step();
      hs_pol = 0; vs_pol = 1; pol_vld = 1; step();
      chk("R3 baseline", 32'(flags[0]), 0);
   endtask

   task automatic t_vtot();
      vt(526); chk("R4 within +1", 32'(flags[0]), 0);
      vt(524); chk("R4 within -1", 32'(flags[0]), 0);
      vt(527); chk("R4 beyond", 32'(flags[0]), 1);
      clr(4'h1); chk("R2 clear fmt", 32'(flags[0]), 0);
   endtask

   task automatic t_vwid();
      vwid = 10; vwid_vld = 1; step();
      vwid = 12; vwid_vld = 1; step();
      chk("R5 within 2", 32'(flags[0]), 0);
      vwid = 13; vwid_vld = 1; step();
      chk("R5 beyond", 32'(flags[0]), 1);
      clr(4'h1);
   endtask

   task automatic t_hper();
      hper = 50000; hper_vld = 1; step();
      hper = 50064; hper_vld = 1; step();
      chk("R6 diff 64", 32'(flags[0]), 0);
      hper = 49935; hper_vld = 1; step();
      chk("R6 diff 65", 32'(flags[0]), 1);
      clr(4'h1);
   endtask

   task automatic t_pol();
      hs_pol = 0; vs_pol = 1; pol_vld = 1; step();
      hs_pol = 0; vs_pol = 1; pol_vld = 1; step();
      chk("R7 same pol", 32'(flags[0]), 0);
      hs_pol = 1; vs_pol = 1; pol_vld = 1; step();
      chk("R7 hs pol flip", 32'(flags[0]), 1);
      clr(4'h1);
   endtask

   task automatic t_base_keep();
      vt(600); vt(601);
      chk("R8 within keeps", 32'(flags[0]), 0);
      vt(602);
      chk("R8 kept baseline", 32'(flags[0]), 1);
      vtot = 603; vtot_vld = 1; clr_wr = 1; clr_mask = 4'h1; step();
      chk("R8 replaced baseline", 32'(flags[0]), 0);
      vt(601);
      chk("R12 clear-cycle sample is baseline", 32'(flags[0]), 1);
      clr(4'h1);
   endtask

   task automatic t_evt_wins();
      vt(800);
      vtot = 900; vtot_vld = 1; clr_wr = 1; clr_mask = 4'h1; step();
      chk("R11 event wins", 32'(flags[0]), 1);
      repeat (3) step();
      chk("R11 sticky", 32'(flags[0]), 1);
      clr(4'h1);
      chk("R11 cleared", 32'(flags[0]), 0);
   endtask

   task automatic t_ports();
      clr(4'h6);
      port_type = 4'b0000; step();
      chk("R9 port0 flag", 32'(flags[2:1]), 2'b01);
      port_type = 4'b1100; step();
      chk("R9 port1 flag", 32'(flags[2:1]), 2'b11);
      clr(4'h2);
      chk("R2 partial clear", 32'(flags[2:1]), 2'b10);
   endtask

   task automatic t_sync();
      clr(4'h8);
      hs_det = 1; step(); step(); step();
      chk("R10 hsync only", 32'(flags[3]), 0);
      vs_det = 1; step();
      chk("R10 not yet", 32'(flags[3]), 0);
      step();
      chk("R10 sync valid", 32'(flags[3]), 1);
      clr(4'h8); step(); step();
      chk("R10 needs new pulses", 32'(flags[3]), 0);
   endtask

   initial begin
      t_reset();
      t_unarmed();
      t_baseline();
      t_vtot();
      t_vwid();
      t_hper();
      t_pol();
      t_base_keep();
      t_evt_wins();
      t_ports();
      t_sync();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule